// File: doc/BRIEF.md
# Sideband Response Error Classifier

This block watches each response frame that a processor returns over its sideband bus and turns it into one set of status fields. Bytes arrive one per valid strobe. A start strobe marks the first byte of a frame and an end strobe marks its last byte, which is the received check byte. The block runs a CRC-8 over the whole frame, check byte included. A frame whose residue is not zero is corrupt. On a clean frame the block then reads two things. The first is the completion code that heads configuration-space responses. The second is a 16-bit temperature word, located at a byte offset the caller supplies, which is compared against the processor's reserved sensor-error values.

The outcome is registered one cycle after the check byte. It shows up in four places: an error status byte that holds the communication-fail bit, the data-error bit and a 3-bit data code; a separate transfer-fail bit; a one-cycle result strobe; and a one-cycle retry request. A retry is requested only for the timeout completion codes, and only while the number of retries granted in the current transaction stays below a programmable limit.

Top module: `sbr_rsp_classifier`

## Requirements
- R1: The check sequence is CRC-8, polynomial x^8+x^2+x+1 (0x07), MSB first, initial value 0x00. It runs over every byte of the frame including the final check byte. A nonzero result sets `comm_fail`, which also appears as bit 2 of `err_status`.
- R2: When `comm_fail` is set, `data_err` is 0, `data_code` is 000, `xfer_fail` is 1 and no retry is requested.
- R3: On a clean frame, the temperature word 0x8000 sets `data_err` (bit 1 of `err_status`) with `data_code` 000 (bits 6:4 of `err_status`).
- R4: The word 0x8002 gives `data_err` with code 001, and 0x8003 gives `data_err` with code 010. Any other word leaves `data_err` at 0 and the code at 000. The word's low byte is at frame byte index `temp_pos` and its high byte at index `temp_pos`+1, where index 0 is the first byte.
- R5: The temperature word is examined only if both its bytes come before the check byte. When `has_cc` is 1, it is also examined only if the completion code is 0x40.
- R6: With `has_cc` = 1, frame byte 0 is the completion code. The code 0x40 gives `xfer_fail` = 0. A frame that has no byte ahead of the check byte gives `xfer_fail` = 1 and no retry.
- R7: The codes 0x80 and 0x81 give `xfer_fail` = 1, and they raise `retry_req` when the retry count is below `retry_max`.
- R8: Each granted retry adds one to the retry count. Any other outcome clears it to 0, and so does `txn_new` sampled with the start strobe. With `retry_max` = 0, no retry is ever requested.
- R9: The codes 0x90 and 0x91, and every code not named in R6 or R7, give `xfer_fail` = 1 and no retry.
- R10: All outputs are 0 after reset. `result_vld` pulses in the cycle after the check byte is accepted. Status outputs change only together with `result_vld`, and `retry_req` is high only during that pulse.
- R11: With `has_cc` = 0, byte 0 is ordinary data, and `xfer_fail` equals `comm_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_start | input | 1 | First byte of a frame (qualified by byte_vld) |
| byte_vld | input | 1 | byte_in carries a frame byte |
| frm_end | input | 1 | This byte is the check byte (qualified by byte_vld) |
| byte_in | input | 8 | Received byte |
| has_cc | input | 1 | Frame begins with a completion code (sampled at start) |
| temp_pos | input | IDX_W | Byte index of the temperature word's low byte (sampled at start) |
| txn_new | input | 1 | First attempt of a new transaction (sampled at start) |
| retry_max | input | RTRY_W | Retry limit per transaction |
| result_vld | output | 1 | One-cycle strobe: new results valid |
| comm_fail | output | 1 | Check sequence mismatch |
| data_err | output | 1 | Sensor error word received |
| data_code | output | 3 | Sensor error kind |
| err_status | output | 8 | Error status byte: bit 6:4 code, bit 2 comm, bit 1 data |
| xfer_fail | output | 1 | Completion status: 1 = access failed |
| retry_req | output | 1 | One-cycle request to reissue the command |

## Verification
The bench runs all 256 completion-code values through one frame shape. This separates pass, retryable-timeout and non-retried failure classes, including codes that neighbour the named ones. It also sweeps the temperature low byte through all 256 values under several high bytes, so the three error words can be told apart from every near miss. Position against length sweeps show whether a word that overlaps or trails the check byte is excluded. Single-bit flips of the check byte, retry chains under several limits, and one-byte frames exercise the corruption masking, the count limit and the missing-code case.

// File: rtl/sbr_pkg.sv
// Package: constants and CRC step shared by the response classifier.
// Assumes MSB-first CRC with no reflection and no final XOR.
package sbr_pkg;
    localparam logic [7:0] CRC_POLY  = 8'h07;
    localparam logic [7:0] CC_PASS   = 8'h40;
    localparam logic [7:0] CC_TMO_A  = 8'h80;
    localparam logic [7:0] CC_TMO_B  = 8'h81;
    localparam logic [15:0] TW_GEN   = 16'h8000;
    localparam logic [15:0] TW_LOW   = 16'h8002;
    localparam logic [15:0] TW_HIGH  = 16'h8003;

    typedef enum logic [2:0] {
        DC_GENERAL = 3'b000,
        DC_UNDER   = 3'b001,
        DC_OVER    = 3'b010
    } dcode_e;

    // One byte through the CRC register, bit by bit.
    function automatic logic [7:0] crc_step(input logic [7:0] crc_in,
                                            input logic [7:0] din,
                                            input logic [7:0] poly);
        logic [7:0] r;
        r = crc_in ^ din;
        for (int i = 0; i < 8; i++) begin
            r = r[7] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/sbr_crc_acc.sv
// CRC accumulator: keeps the running CRC over the frame's bytes.
// crc_nxt is the value that includes the current byte. The start strobe
// reseeds from zero, so a start byte does not depend on the old register.
module sbr_crc_acc
    import sbr_pkg::*;
#(
    parameter logic [7:0] POLY = CRC_POLY
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       vld,
    input  logic [7:0] din,
    output logic [7:0] crc_nxt
);
    logic [7:0] crc_q;

    // Next CRC value, seeded at zero on the first byte.
    always_comb crc_nxt = crc_step(sof ? 8'h00 : crc_q, din, POLY);

    // Running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc_q <= 8'h00;
        else if (vld) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/sbr_field_grab.sv
// Field capture: picks the completion-code byte (index 0) and the two
// temperature bytes (pos, pos+1) out of the stream, without buffering.
// Only bytes ahead of the check byte are captured. The outputs describe
// the bytes received before the current cycle; a start strobe reads as
// "nothing seen yet".
module sbr_field_grab #(
    parameter int MAX_LEN = 16,
    parameter int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             vld,
    input  logic             last,
    input  logic [7:0]       din,
    input  logic [IDX_W-1:0] pos_in,
    output logic [7:0]       cc_byte,
    output logic             cc_seen,
    output logic [15:0]      tword,
    output logic             tw_seen
);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_LEN - 1);

    logic [IDX_W-1:0] idx_q, pos_q, cur_idx, pos_eff;
    logic [7:0]       cc_q, lo_q, hi_q;
    logic             cc_v_q, lo_v_q, hi_v_q;
    logic             fl_cc, fl_lo, fl_hi;
    logic             hit_cc, hit_lo, hit_hi, data_byte;

    // Current byte index and frame parameters; a start byte restarts both.
    always_comb begin
        cur_idx   = sof ? '0 : idx_q;
        pos_eff   = sof ? pos_in : pos_q;
        fl_cc     = sof ? 1'b0 : cc_v_q;
        fl_lo     = sof ? 1'b0 : lo_v_q;
        fl_hi     = sof ? 1'b0 : hi_v_q;
        data_byte = vld && !last;
        hit_cc    = data_byte && (cur_idx == '0);
        hit_lo    = data_byte && (cur_idx == pos_eff);
        hit_hi    = data_byte && ({1'b0, cur_idx} == ({1'b0, pos_eff} + 1'b1));
    end

    // Index counter, saturating at the last index.
    always_ff @(posedge clk) begin
        if (!rst_n)   idx_q <= '0;
        else if (vld) idx_q <= (cur_idx == IDX_TOP) ? cur_idx : cur_idx + 1'b1;
    end

    // Latch the word position with the start byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   pos_q <= '0;
        else if (sof) pos_q <= pos_in;
    end

    // Capture the bytes that match, and track which fields are complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q <= 8'h00; lo_q <= 8'h00; hi_q <= 8'h00;
            cc_v_q <= 1'b0; lo_v_q <= 1'b0; hi_v_q <= 1'b0;
        end else if (vld) begin
            if (hit_cc) cc_q <= din;
            if (hit_lo) lo_q <= din;
            if (hit_hi) hi_q <= din;
            cc_v_q <= fl_cc | hit_cc;
            lo_v_q <= fl_lo | hit_lo;
            hi_v_q <= fl_hi | hit_hi;
        end
    end

    // Field views for the evaluation cycle.
    always_comb begin
        cc_byte = cc_q;
        cc_seen = fl_cc;
        tword   = {hi_q, lo_q};
        tw_seen = fl_lo && fl_hi;
    end
endmodule

// File: rtl/sbr_retry_ctl.sv
// Retry limiter: counts the retries granted in the current transaction
// and grants another only while the count is below the limit. Any result
// without a retry clears the count; so does a new transaction.
module sbr_retry_ctl #(
    parameter int RTRY_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              eval,
    input  logic              want,
    input  logic [RTRY_W-1:0] max_cnt,
    output logic              grant,
    output logic [RTRY_W-1:0] cnt_q
);
    logic [RTRY_W-1:0] eff;

    // Effective count for this frame and the grant decision.
    always_comb begin
        eff   = clr ? '0 : cnt_q;
        grant = eval && want && (eff < max_cnt);
    end

    // Count update at evaluation, or clear at transaction start.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (eval) cnt_q <= grant ? eff + 1'b1 : '0;
        else if (clr)  cnt_q <= '0;
    end
endmodule

// File: rtl/sbr_rsp_classifier.sv
// Response classifier top: combines the integrity check, completion-code
// class and sensor-error word into registered status fields. It assumes
// that frm_start and frm_end count only together with byte_vld, and that
// has_cc, temp_pos and txn_new are valid with the start byte.
module sbr_rsp_classifier
    import sbr_pkg::*;
#(
    parameter  int MAX_LEN = 16,
    parameter  int RTRY_W  = 3,
    localparam int IDX_W   = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              byte_vld,
    input  logic              frm_end,
    input  logic [7:0]        byte_in,
    input  logic              has_cc,
    input  logic [IDX_W-1:0]  temp_pos,
    input  logic              txn_new,
    input  logic [RTRY_W-1:0] retry_max,
    output logic              result_vld,
    output logic              comm_fail,
    output logic              data_err,
    output logic [2:0]        data_code,
    output logic [7:0]        err_status,
    output logic              xfer_fail,
    output logic              retry_req
);
    logic              sof, eval, hcc_q, hcc_eff;
    logic [7:0]        crc_fin, cc_byte;
    logic              cc_seen, tw_seen;
    logic [15:0]       tword;
    logic              crc_bad, cc_ok, cc_tmo, temp_chk, want, grant;
    logic              derr_n, fail_n;
    logic [2:0]        code_n;
    logic [RTRY_W-1:0] retry_cnt;

    // Frame strobes, each qualified by the byte strobe.
    always_comb begin
        sof     = byte_vld && frm_start;
        eval    = byte_vld && frm_end;
        hcc_eff = sof ? has_cc : hcc_q;
    end

    // Latch whether the frame carries a completion code.
    always_ff @(posedge clk) begin
        if (!rst_n)   hcc_q <= 1'b0;
        else if (sof) hcc_q <= has_cc;
    end

    sbr_crc_acc #(.POLY(CRC_POLY)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sof),
        .vld     (byte_vld),
        .din     (byte_in),
        .crc_nxt (crc_fin)
    );

    sbr_field_grab #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_grab (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sof),
        .vld     (byte_vld),
        .last    (frm_end),
        .din     (byte_in),
        .pos_in  (temp_pos),
        .cc_byte (cc_byte),
        .cc_seen (cc_seen),
        .tword   (tword),
        .tw_seen (tw_seen)
    );

    sbr_retry_ctl #(.RTRY_W(RTRY_W)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sof && txn_new),
        .eval    (eval),
        .want    (want),
        .max_cnt (retry_max),
        .grant   (grant),
        .cnt_q   (retry_cnt)
    );

    // Classify the frame as its check byte arrives.
    always_comb begin
        crc_bad  = (crc_fin != 8'h00);
        cc_ok    = cc_seen && (cc_byte == CC_PASS);
        cc_tmo   = cc_seen && ((cc_byte == CC_TMO_A) || (cc_byte == CC_TMO_B));
        temp_chk = !crc_bad && tw_seen && (!hcc_eff || cc_ok);
        want     = !crc_bad && hcc_eff && cc_tmo;
        fail_n   = crc_bad || (hcc_eff && !cc_ok);
        derr_n   = 1'b0;
        code_n   = DC_GENERAL;
        if (temp_chk) begin
            unique case (tword)
                TW_GEN:  begin derr_n = 1'b1; code_n = DC_GENERAL; end
                TW_LOW:  begin derr_n = 1'b1; code_n = DC_UNDER;   end
                TW_HIGH: begin derr_n = 1'b1; code_n = DC_OVER;    end
                default: begin derr_n = 1'b0; code_n = DC_GENERAL; end
            endcase
        end
    end

    // Register the results; strobes last one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld <= 1'b0;
            retry_req  <= 1'b0;
            comm_fail  <= 1'b0;
            data_err   <= 1'b0;
            data_code  <= 3'b000;
            xfer_fail  <= 1'b0;
        end else begin
            result_vld <= eval;
            retry_req  <= grant;
            if (eval) begin
                comm_fail <= crc_bad;
                data_err  <= derr_n;
                data_code <= code_n;
                xfer_fail <= fail_n;
            end
        end
    end

    // Error status byte layout.
    always_comb err_status = {1'b0, data_code, 1'b0, comm_fail, data_err, 1'b0};
endmodule

// Checker: temporal rules for the classifier outputs.
module sbr_rsp_chk #(
    parameter int RTRY_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_vld,
    input logic              frm_end,
    input logic              result_vld,
    input logic              comm_fail,
    input logic              data_err,
    input logic [2:0]        data_code,
    input logic [7:0]        err_status,
    input logic              xfer_fail,
    input logic              retry_req,
    input logic [RTRY_W-1:0] retry_max,
    input logic [RTRY_W-1:0] retry_cnt
);
    assert_vld_follows_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && frm_end) |=> result_vld);
    assert_vld_only_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |-> $past(byte_vld && frm_end));
    assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> ($stable(err_status) && $stable(xfer_fail)));
    assert_comm_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        comm_fail |-> (xfer_fail && !data_err && !retry_req));
    assert_code_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_err |-> data_code == 3'b000) and (data_code <= 3'b010));
    assert_retry_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> (result_vld && xfer_fail));
    assert_retry_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> (retry_cnt != '0 && retry_cnt <= retry_max));
endmodule

bind sbr_rsp_classifier sbr_rsp_chk #(.RTRY_W(RTRY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .frm_end    (frm_end),
    .result_vld (result_vld),
    .comm_fail  (comm_fail),
    .data_err   (data_err),
    .data_code  (data_code),
    .err_status (err_status),
    .xfer_fail  (xfer_fail),
    .retry_req  (retry_req),
    .retry_max  (retry_max),
    .retry_cnt  (retry_cnt)
);

// File: tb/sim_sbr_rsp_classifier.sv
// Bench: sweeps completion codes, temperature words, positions, check-byte
// corruption and retry chains; the expected outcome is worked out per frame.
module sim_sbr_rsp_classifier;
    localparam int MAX_LEN = 16;
    localparam int RTRY_W  = 3;
    localparam int IDX_W   = $clog2(MAX_LEN);

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_start = 0, byte_vld = 0, frm_end = 0, has_cc = 0, txn_new = 0;
    logic [7:0] byte_in = 0;
    logic [IDX_W-1:0] temp_pos = 0;
    logic [RTRY_W-1:0] retry_max = 0;
    logic result_vld, comm_fail, data_err, xfer_fail, retry_req;
    logic [2:0] data_code;
    logic [7:0] err_status;

    int checks = 0, fails = 0, cyc = 0, cnt_m = 0;
    logic [7:0] d [0:15];

    always #5 clk = ~clk;

    sbr_rsp_classifier #(.MAX_LEN(MAX_LEN), .RTRY_W(RTRY_W)) u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1; checks = checks + 1;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] crc8(int n);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < n; i++) begin
            r = r ^ d[i];
            for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [14:0] got, logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // Send n data bytes plus the check byte, then compare with the expected outcome.
    task automatic send(int n, bit hcc, int pos, bit txn, logic [7:0] cmask, string tag);
        logic [7:0] fcs = crc8(n) ^ cmask;
        bit comm, derr, xf, rt, tchk, cok, tmo;
        logic [2:0] code;
        logic [15:0] w;
        int eff;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            byte_vld = 1; frm_start = (i == 0); frm_end = (i == n);
            byte_in = (i < n) ? d[i] : fcs;
            has_cc = hcc; temp_pos = IDX_W'(pos); txn_new = txn;
        end
        @(negedge clk);
        byte_vld = 0; frm_start = 0; frm_end = 0;
        comm = (cmask != 0);
        cok  = hcc && n >= 1 && d[0] == 8'h40;
        tmo  = hcc && n >= 1 && (d[0] == 8'h80 || d[0] == 8'h81);
        tchk = !comm && (pos + 1 < n) && (!hcc || cok);
        w = (pos + 1 < n) ? {d[pos+1], d[pos]} : 16'h0;
        derr = tchk && (w == 16'h8000 || w == 16'h8002 || w == 16'h8003);
        code = !derr ? 3'd0 : (w == 16'h8002) ? 3'd1 : (w == 16'h8003) ? 3'd2 : 3'd0;
        xf = comm || (hcc && !cok);
        eff = txn ? 0 : cnt_m;
        rt = !comm && tmo && (eff < int'(retry_max));
        cnt_m = rt ? eff + 1 : 0;
        chk(tag, {result_vld, comm_fail, data_err, data_code, xf ? xfer_fail : ~xfer_fail, retry_req, err_status},
                 {1'b1, comm, derr, code, 1'b1, rt, {1'b0, code, 1'b0, comm, derr, 1'b0}});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset", {result_vld, comm_fail, data_err, data_code, xfer_fail, retry_req, err_status}, 15'h0);
        rst_n = 1;
        retry_max = 3'd2;
        // R6 R7 R9: every completion code
        for (int c = 0; c < 256; c++) begin
            d[0] = 8'(c); d[1] = 8'h11; d[2] = 8'h22; d[3] = 8'h33;
            send(4, 1, 1, 1, 8'h00, (c == 8'h40) ? "R6 pass" :
                 (c == 8'h80 || c == 8'h81) ? "R7 timeout" : "R9 no retry");
        end
        // R3 R4: temperature word sweep
        for (int h = 0; h < 4; h++) begin
            for (int l = 0; l < 256; l++) begin
                d[0] = 8'h5A; d[1] = 8'hA5; d[2] = 8'(l);
                d[3] = (h == 0) ? 8'h80 : (h == 1) ? 8'h7F : (h == 2) ? 8'h00 : 8'h81;
                d[4] = 8'hC3;
                send(5, 0, 2, 1, 8'h00, (h == 0 && l == 0) ? "R3 general word" : "R4 word decode");
            end
        end
        // R5: position against length
        for (int n = 1; n <= 8; n++) begin
            for (int p = 0; p < 8; p++) begin
                for (int i = 0; i < 16; i++) d[i] = 8'h03;
                d[p] = 8'h03; d[p+1] = 8'h80;
                send(n, 0, p, 1, 8'h00, "R5 word position");
            end
        end
        // R5: failed completion code suppresses the word
        d[0] = 8'h90; d[1] = 8'h00; d[2] = 8'h80;
        send(3, 1, 1, 1, 8'h00, "R5 code gates word");
        d[0] = 8'h40;
        send(3, 1, 1, 1, 8'h00, "R5 code passes word");
        // R1 R2: single-bit flips of the check byte
        for (int b = 0; b < 8; b++) begin
            d[0] = 8'h80; d[1] = 8'h02; d[2] = 8'h80;
            send(3, 1, 1, 1, 8'(1 << b), "R1 R2 corrupt check");
        end
        // R11: code byte ignored when not flagged
        d[0] = 8'h80; d[1] = 8'h00; d[2] = 8'h80;
        send(3, 0, 1, 1, 8'h00, "R11 no code");
        // R6: empty frame with code expected
        send(0, 1, 0, 1, 8'h00, "R6 missing code");
        // R8: retry chains under several limits
        for (int m = 0; m < 4; m++) begin
            retry_max = RTRY_W'(m);
            d[0] = 8'h81; d[1] = 8'h00; d[2] = 8'h00;
            for (int k = 0; k < 6; k++) send(3, 1, 0, k == 0, 8'h00, "R8 retry limit");
            send(3, 1, 0, 1, 8'h00, "R8 new transaction");
            d[0] = 8'h40;
            send(3, 1, 0, 0, 8'h00, "R8 pass clears");
            d[0] = 8'h80;
            send(3, 1, 0, 0, 8'h00, "R8 after clear");
        end
        // R10: outputs hold while idle
        repeat (4) @(negedge clk);
        chk("R10 hold", {result_vld, retry_req, xfer_fail, err_status, 4'h0}, {1'b0, 1'b0, 1'b1, 8'h00, 4'h0});
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule